// File: doc/BRIEF.md
# Two-Channel Buffer Bus Arbiter

This block decides which of two 16-bit DMA channels may drive the shared buffer RAM bus. The network-side channel ("local") serves packet traffic. The host-side slave channel ("remote") moves data between buffer RAM and the host. When either channel wants the bus, the arbiter asks for the external bus with a request signal and waits for the acknowledge. It then grants exactly one channel, and the local channel wins any contest. The granted channel keeps the bus until it signals that its burst is finished.

All bus timing runs from one bus clock. A mode input selects shared-memory operation. In that mode the host reaches buffer RAM directly, so the remote channel is never served. The arbiter also steers the address and write data of the granted channel onto the shared bus.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_req`, both grants, `bus_addr` and `bus_wdata` are all zero.
- R2: From idle, an eligible request raises `bus_req` on the next clock edge. A request is eligible if it is `loc_req`, or `rem_req` with `shared_mode` low. No grant appears before `bus_ack` is seen.
- R3: No grant is high in any cycle in which `bus_ack` is low. An owner that loses acknowledge keeps ownership, and its grant returns when `bus_ack` returns.
- R4: When both channels are eligible at the arbitration edge and `bus_ack` is high, the local channel is granted.
- R5: A granted channel keeps its grant, even against a pending local request, until its done input is sampled high.
- R6: The clock edge that samples the owner's done removes that grant. The next grant goes out one cycle later, and a pending local request wins it.
- R7: If no eligible request remains in the cycle after the last release, `bus_req` falls on the next edge. That is one clock after the release.
- R8: With `shared_mode` high, `rem_gnt` is never high, a lone `rem_req` does not raise `bus_req`, and a remote owner loses the bus at the next edge.
- R9: `loc_gnt` and `rem_gnt` are never high together.
- R10: `bus_addr` and `bus_wdata` carry the granted channel's address and write data, and are zero when neither channel is granted.
- R11: If every request is withdrawn while waiting for acknowledge, `bus_req` falls at the next edge and nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock shared by both channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| shared_mode | input | 1 | High: host has direct RAM access, remote channel disabled |
| loc_req | input | 1 | Local channel wants the bus |
| loc_done | input | 1 | Local channel burst finished |
| loc_addr | input | ADDR_W | Local channel address |
| loc_wdata | input | DATA_W | Local channel write data |
| rem_req | input | 1 | Remote channel wants the bus |
| rem_done | input | 1 | Remote channel burst finished |
| rem_addr | input | ADDR_W | Remote channel address |
| rem_wdata | input | DATA_W | Remote channel write data |
| bus_ack | input | 1 | External bus acknowledge |
| bus_req | output | 1 | External bus request |
| loc_gnt | output | 1 | Local channel owns the bus this cycle |
| rem_gnt | output | 1 | Remote channel owns the bus this cycle |
| bus_addr | output | ADDR_W | Address driven to buffer RAM |
| bus_wdata | output | DATA_W | Write data driven to buffer RAM |

## Verification
The hardest case to reach is a remote channel that is mid-burst when a local request arrives. The local request must wait and then win the very next grant. Reaching it needs the remote channel to be granted alone first. Only then is the local request raised, and the stimulus keeps both requests up across the remote done. A second hard case revokes a remote owner by switching `shared_mode` on while it holds the bus. The stimulus vectors hold `bus_ack` high across both cases, so the grant hand-off and the gated request can be seen at the ports.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE    = 2'd0,
      ARB_WAIT    = 2'd1,
      ARB_OWN_LOC = 2'd2,
      ARB_OWN_REM = 2'd3
   } arb_state_t;

   typedef enum logic {
      CH_LOC = 1'b0,
      CH_REM = 1'b1
   } arb_chan_t;

   localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/dma_arb_select.sv
module dma_arb_select
   import dma_arb_pkg::*;
#(
   parameter bit HAS_REMOTE = 1'b1
) (
   input  logic      shared_mode,
   input  logic      loc_req,
   input  logic      rem_req,
   output logic      loc_pend,
   output logic      rem_pend,
   output logic      any_pend,
   output arb_chan_t pick
);

   assign loc_pend = loc_req;

   generate
      if (HAS_REMOTE) begin : g_remote
         assign rem_pend = rem_req & ~shared_mode;
      end else begin : g_no_remote
         logic unused_rem;
         assign unused_rem = rem_req ^ shared_mode;
         assign rem_pend   = 1'b0;
      end
   endgenerate

   assign any_pend = loc_pend | rem_pend;
   // fixed priority: local first
   assign pick     = loc_pend ? CH_LOC : CH_REM;

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
   import dma_arb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      shared_mode,
   input  logic      loc_pend,
   input  logic      any_pend,
   input  arb_chan_t pick,
   input  logic      loc_done,
   input  logic      rem_done,
   input  logic      bus_ack,
   output logic      bus_req,
   output logic      loc_gnt,
   output logic      rem_gnt
);

   arb_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_IDLE: begin
            if (any_pend) state_d = ARB_WAIT;
         end
         ARB_WAIT: begin
            if (!any_pend)   state_d = ARB_IDLE;
            else if (bus_ack) state_d = (pick == CH_LOC) ? ARB_OWN_LOC : ARB_OWN_REM;
         end
         ARB_OWN_LOC: begin
            if (loc_done) state_d = ARB_WAIT;
         end
         ARB_OWN_REM: begin
            if (rem_done || shared_mode) state_d = ARB_WAIT;
         end
         default: state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign bus_req = (state_q != ARB_IDLE);
   assign loc_gnt = (state_q == ARB_OWN_LOC) & bus_ack;
   assign rem_gnt = (state_q == ARB_OWN_REM) & bus_ack & ~shared_mode;

   AST_IDLE_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_IDLE && any_pend) |=> bus_req); // R2

   AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_WAIT && bus_ack && loc_pend) |=> (state_q == ARB_OWN_LOC)); // R4

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_WAIT && !any_pend) |=> !bus_req); // R7

endmodule

// File: rtl/dma_arb_mux.sv
module dma_arb_mux
   import dma_arb_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic [NUM_CH-1:0]             gnt,
   input  logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr,
   input  logic [NUM_CH-1:0][DATA_W-1:0] ch_wdata,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic [DATA_W-1:0]             bus_wdata
);

   logic [NUM_CH-1:0][ADDR_W-1:0] addr_m;
   logic [NUM_CH-1:0][DATA_W-1:0] data_m;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign addr_m[c] = {ADDR_W{gnt[c]}} & ch_addr[c];
      assign data_m[c] = {DATA_W{gnt[c]}} & ch_wdata[c];
   end

   always_comb begin
      bus_addr  = '0;
      bus_wdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         bus_addr  = bus_addr  | addr_m[c];
         bus_wdata = bus_wdata | data_m[c];
      end
   end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 16,
   parameter bit          HAS_REMOTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shared_mode,
   input  logic              loc_req,
   input  logic              loc_done,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic [DATA_W-1:0] loc_wdata,
   input  logic              rem_req,
   input  logic              rem_done,
   input  logic [ADDR_W-1:0] rem_addr,
   input  logic [DATA_W-1:0] rem_wdata,
   input  logic              bus_ack,
   output logic              bus_req,
   output logic              loc_gnt,
   output logic              rem_gnt,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata
);

   localparam int unsigned DATA_BYTES = DATA_W / 8;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("dma_bus_arbiter: ADDR_W must be at least 1");
      end
      if (DATA_W < 8 || (DATA_BYTES * 8) != DATA_W) begin : g_bad_data
         $error("dma_bus_arbiter: DATA_W must be a whole number of bytes");
      end
   endgenerate

   logic      loc_pend, rem_pend, any_pend;
   arb_chan_t pick;

   dma_arb_select #(.HAS_REMOTE(HAS_REMOTE)) i_select (
      .shared_mode (shared_mode),
      .loc_req     (loc_req),
      .rem_req     (rem_req),
      .loc_pend    (loc_pend),
      .rem_pend    (rem_pend),
      .any_pend    (any_pend),
      .pick        (pick)
   );

   dma_arb_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .shared_mode (shared_mode),
      .loc_pend    (loc_pend),
      .any_pend    (any_pend),
      .pick        (pick),
      .loc_done    (loc_done),
      .rem_done    (rem_done),
      .bus_ack     (bus_ack),
      .bus_req     (bus_req),
      .loc_gnt     (loc_gnt),
      .rem_gnt     (rem_gnt)
   );

   dma_arb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mux (
      .gnt       ({rem_gnt, loc_gnt}),
      .ch_addr   ({rem_addr, loc_addr}),
      .ch_wdata  ({rem_wdata, loc_wdata}),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata)
   );

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_gnt && rem_gnt)); // R9

   AST_NO_GNT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack |-> (!loc_gnt && !rem_gnt)); // R3

   AST_SHARED_NO_REM: assert property (@(posedge clk) disable iff (!rst_n)
      shared_mode |-> !rem_gnt); // R8

   AST_REM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rem_pend |-> !shared_mode); // R8

   AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(loc_gnt && !loc_done) && bus_ack) |-> loc_gnt); // R5

   AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rem_gnt && !rem_done && !shared_mode) && bus_ack && !shared_mode) |-> rem_gnt); // R5

   AST_LOC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(loc_gnt && loc_done) |-> !loc_gnt); // R6

   AST_REM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rem_gnt && rem_done) |-> !rem_gnt); // R6

   AST_BUS_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      loc_gnt |-> (bus_addr == loc_addr && bus_wdata == loc_wdata)); // R10

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!loc_gnt && !rem_gnt) |-> (bus_addr == '0 && bus_wdata == '0)); // R10

endmodule

// File: tb/test_dma_bus_arbiter.sv
module test_dma_bus_arbiter;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 16;
   localparam int NVEC   = 21;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              shared_mode = 1'b0;
   logic              loc_req = 1'b0, loc_done = 1'b0;
   logic              rem_req = 1'b0, rem_done = 1'b0;
   logic              bus_ack = 1'b0;
   logic [ADDR_W-1:0] loc_addr = 16'h1A2B, rem_addr = 16'hC3D4;
   logic [DATA_W-1:0] loc_wdata = 16'h5566, rem_wdata = 16'h9ABC;
   logic              bus_req, loc_gnt, rem_gnt;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dma_bus_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dma_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
      .loc_req(loc_req), .loc_done(loc_done), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
      .rem_req(rem_req), .rem_done(rem_done), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
      .bus_ack(bus_ack), .bus_req(bus_req), .loc_gnt(loc_gnt), .rem_gnt(rem_gnt),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata)
   );

   // {shared, lreq, ldone, rreq, rdone, ack, exp_req, exp_lgnt, exp_rgnt}
   localparam logic [8:0] VEC [NVEC] = '{
      9'b000000_000, // idle
      9'b010000_100, // R2 request rises
      9'b010000_100, // R3 waiting for ack
      9'b010101_110, // R4 both pending, local wins
      9'b010100_100, // R3 ack lost, grant hidden
      9'b010101_110, // R3 grant back with ack
      9'b011101_100, // R6 local done, grant drops
      9'b000101_101, // remote granted alone
      9'b010101_101, // R5 local cannot preempt
      9'b010111_100, // R6 remote done
      9'b010101_110, // R6 pending local wins next
      9'b001001_100, // local done, nothing pending
      9'b000001_000, // R7 request falls one clock later
      9'b100101_000, // R8 lone remote in shared mode
      9'b100101_000, // R8 still idle
      9'b000100_100, // remote eligible again
      9'b000101_101, // remote granted
      9'b100101_100, // R8 revoked by shared mode
      9'b100101_000, // R8 R7 back to idle
      9'b010000_100, // R11 request before ack
      9'b000000_000  // R11 withdrawn
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_bus(input logic lg, input logic rg);
      logic [ADDR_W-1:0] ea;
      logic [DATA_W-1:0] ed;
      ea = lg ? loc_addr  : (rg ? rem_addr  : '0);
      ed = lg ? loc_wdata : (rg ? rem_wdata : '0);
      chk("R10 bus_addr", 32'(bus_addr), 32'(ea));
      chk("R10 bus_wdata", 32'(bus_wdata), 32'(ed));
   endtask

   initial begin
      #(20 * 2000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      loc_req = 1'b1; rem_req = 1'b1; bus_ack = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 bus_req in reset", 32'(bus_req), 0);
      chk("R1 grants in reset", 32'({loc_gnt, rem_gnt}), 0);
      check_bus(1'b0, 1'b0);
      loc_req = 1'b0; rem_req = 1'b0; bus_ack = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bus_req after reset", 32'(bus_req), 0);

      for (int i = 0; i < NVEC; i++) begin
         {shared_mode, loc_req, loc_done, rem_req, rem_done, bus_ack} = VEC[i][8:3];
         @(posedge clk);
         @(negedge clk);
         chk($sformatf("vec%0d bus_req", i), 32'(bus_req), 32'(VEC[i][2]));
         chk($sformatf("vec%0d loc_gnt", i), 32'(loc_gnt), 32'(VEC[i][1]));
         chk($sformatf("vec%0d rem_gnt", i), 32'(rem_gnt), 32'(VEC[i][0]));
         chk("R9 single grant", 32'(loc_gnt & rem_gnt), 0);
         check_bus(VEC[i][1], VEC[i][0]);
      end

      // R1 reset while local owns the bus
      shared_mode = 1'b0; loc_req = 1'b1; bus_ack = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 setup local owns", 32'(loc_gnt), 1);
      rst_n = 1'b0;
      #1;
      chk("R1 async reset clears grant", 32'({bus_req, loc_gnt, rem_gnt}), 0);
      check_bus(1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1; loc_req = 1'b0; bus_ack = 1'b0;
      @(negedge clk);
      chk("R1 idle after reset", 32'(bus_req), 0);

      // R5 long burst with changing address, local held over many cycles
      loc_req = 1'b1; bus_ack = 1'b1; rem_req = 1'b1;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 5; k++) begin
         loc_addr = 16'(16'h0100 + k);
         @(negedge clk);
         chk("R5 local held", 32'(loc_gnt), 1);
         check_bus(1'b1, 1'b0);
      end
      loc_done = 1'b1; loc_req = 1'b0;
      @(negedge clk);
      loc_done = 1'b0;
      chk("R6 no grant in handover cycle", 32'({loc_gnt, rem_gnt}), 0);
      @(negedge clk);
      chk("R6 remote next", 32'(rem_gnt), 1);
      check_bus(1'b0, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule